// File: doc/BRIEF.md
# Per-Register Vector Configuration Decoder

This decode-stage unit looks at the register operands named by an instruction (one destination and up to two sources, each tagged as integer or floating-point). For each operand it reports a vector length and a packed element width. The unit keeps two "is vector" masks with one bit per register, one mask for each register file. It also keeps a small table of configuration entries. Each entry ties one register of one file to a length and a width.

A register whose mask bit is set is looked up in the table. The first enabled entry whose file and index match supplies the operand's length and width. Any other operand is treated as a scalar: its length is 1 and its width is the default width that the opcode decoder supplies. From the per-operand results the unit derives a two-bit instruction class and a bypass flag. When bypass is high, downstream vector sequencing can stay idle.

The lookup is purely combinational from registered state, so it adds no pipeline stage. A single-cycle configuration write port loads the masks and the entries. A written value is seen by decodes from the following cycle onward.

Top module: `vcfg_decoder`

## Requirements
- R1: After reset every mask bit is clear and every entry is disabled. Every enabled operand then reports length 1 and the default width, the class is 0, and bypass is high.
- R2: If an operand's mask bit in its own file is clear, the operand reports length 1 and the default width, even when an enabled entry matches it. Write address 0 loads the integer mask and address 1 loads the floating-point mask, with bit n standing for register n.
- R3: Write address 2+k loads entry k. The data fields are: bits 4:0 register index, bit 7 file (1 = floating-point), bits 15:8 vector length, bits 17:16 packed width, bit 31 enable. A masked operand that matches an enabled entry reports that entry's length and width.
- R4: An entry matches only operands of its own file. An operand of the other file with the same index does not match it.
- R5: When several enabled entries match, the entry with the lowest number supplies the result.
- R6: A masked operand that matches no enabled entry reports length 1 and the default width.
- R7: The class is {any packed, any vector}. Bit 0 is set when some enabled operand has length above 1. Bit 1 is set when some enabled operand has a width different from the default. So 0 = pass-through, 1 = vector, 2 = packed only, 3 = vector-packed.
- R8: Bypass is high exactly when the class is pass-through (0).
- R9: A configuration write does not change the decode in the cycle it is presented. It is seen from the next cycle onward.
- R10: A disabled operand reports length 1 and the default width and does not affect the class.
- R11: An entry whose enable bit is 0 never matches, whatever its index and file.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Write target: 0 integer mask, 1 float mask, 2+k entry k |
| cfg_wdata | input | 32 | Write data |
| def_width | input | 2 | Default element width for the current opcode |
| dst_en | input | 1 | Destination operand present |
| dst_fp | input | 1 | Destination is a floating-point register |
| dst_idx | input | 5 | Destination register number |
| src1_en | input | 1 | First source present |
| src1_fp | input | 1 | First source is floating-point |
| src1_idx | input | 5 | First source register number |
| src2_en | input | 1 | Second source present |
| src2_fp | input | 1 | Second source is floating-point |
| src2_idx | input | 5 | Second source register number |
| dst_vlen | output | 8 | Destination vector length |
| dst_width | output | 2 | Destination element width |
| src1_vlen | output | 8 | First source vector length |
| src1_width | output | 2 | First source element width |
| src2_vlen | output | 8 | Second source vector length |
| src2_width | output | 2 | Second source element width |
| insn_class | output | 2 | Instruction class per R7 |
| bypass | output | 1 | Vector logic may stay idle |

## Verification
The hardest case to reach is two enabled entries that both match the same register of the same file. Checking the priority between them, and then what happens once the winning entry is disabled, needs a sequence of writes that builds that overlap on purpose. The bench loads both entries with the same index. It checks that the lower entry wins. It then rewrites the lower entry with its enable bit cleared and checks that the higher entry's values show through. Another case needs care: a mask bit and an entry can disagree. The bench programs an entry while the mask bit is still clear, and again with the mask bit set for the other file, so that the mask gating and the file match are each exercised alone.

// File: rtl/vcfg_pkg.sv
package vcfg_pkg;
  typedef enum logic [1:0] {
    CLS_PASS  = 2'd0,
    CLS_VEC   = 2'd1,
    CLS_PACK  = 2'd2,
    CLS_VPACK = 2'd3
  } insn_class_e;

  localparam int unsigned CFG_DW     = 32;
  localparam int unsigned FLD_IDX_LO = 0;
  localparam int unsigned FLD_FP     = 7;
  localparam int unsigned FLD_VLEN_LO = 8;
  localparam int unsigned FLD_WID_LO = 16;
  localparam int unsigned FLD_EN     = 31;
  localparam int unsigned ADDR_IMASK = 0;
  localparam int unsigned ADDR_FMASK = 1;
  localparam int unsigned ADDR_ENT0  = 2;
endpackage

// File: rtl/vcfg_store.sv
module vcfg_store
  import vcfg_pkg::*;
#(
  parameter int unsigned NREGS = 32,
  parameter int unsigned NENT  = 2,
  parameter int unsigned IDXW  = 5,
  parameter int unsigned VLW   = 8,
  parameter int unsigned PBW   = 2,
  parameter int unsigned ADDRW = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDRW-1:0]  addr,
  input  logic [CFG_DW-1:0] wdata,
  output logic [NREGS-1:0]  int_mask,
  output logic [NREGS-1:0]  fp_mask,
  output logic              ent_en   [NENT],
  output logic              ent_fp   [NENT],
  output logic [IDXW-1:0]   ent_idx  [NENT],
  output logic [VLW-1:0]    ent_vlen [NENT],
  output logic [PBW-1:0]    ent_wid  [NENT]
);
  logic [NREGS-1:0] int_mask_nxt, fp_mask_nxt;
  logic             imask_ce, fmask_ce;

  always_comb begin
    imask_ce     = we && (addr == ADDRW'(ADDR_IMASK));
    fmask_ce     = we && (addr == ADDRW'(ADDR_FMASK));
    int_mask_nxt = wdata[NREGS-1:0];
    fp_mask_nxt  = wdata[NREGS-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_mask <= '0;
      fp_mask  <= '0;
    end else begin
      if (imask_ce) int_mask <= int_mask_nxt;
      if (fmask_ce) fp_mask  <= fp_mask_nxt;
    end
  end

  for (genvar k = 0; k < NENT; k++) begin : g_ent
    logic            ce;
    logic            en_nxt, fp_nxt;
    logic [IDXW-1:0] idx_nxt;
    logic [VLW-1:0]  vlen_nxt;
    logic [PBW-1:0]  wid_nxt;

    always_comb begin
      ce       = we && (addr == ADDRW'(ADDR_ENT0 + k));
      en_nxt   = wdata[FLD_EN];
      fp_nxt   = wdata[FLD_FP];
      idx_nxt  = wdata[FLD_IDX_LO +: IDXW];
      vlen_nxt = wdata[FLD_VLEN_LO +: VLW];
      wid_nxt  = wdata[FLD_WID_LO +: PBW];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_en[k]   <= 1'b0;
        ent_fp[k]   <= 1'b0;
        ent_idx[k]  <= '0;
        ent_vlen[k] <= VLW'(1);
        ent_wid[k]  <= '0;
      end else if (ce) begin
        ent_en[k]   <= en_nxt;
        ent_fp[k]   <= fp_nxt;
        ent_idx[k]  <= idx_nxt;
        ent_vlen[k] <= vlen_nxt;
        ent_wid[k]  <= wid_nxt;
      end
    end
  end
endmodule

// File: rtl/vcfg_lookup.sv
module vcfg_lookup #(
  parameter int unsigned NREGS = 32,
  parameter int unsigned NENT  = 2,
  parameter int unsigned IDXW  = 5,
  parameter int unsigned VLW   = 8,
  parameter int unsigned PBW   = 2
) (
  input  logic             op_en,
  input  logic             op_fp,
  input  logic [IDXW-1:0]  op_idx,
  input  logic [PBW-1:0]   def_width,
  input  logic [NREGS-1:0] int_mask,
  input  logic [NREGS-1:0] fp_mask,
  input  logic             ent_en   [NENT],
  input  logic             ent_fp   [NENT],
  input  logic [IDXW-1:0]  ent_idx  [NENT],
  input  logic [VLW-1:0]   ent_vlen [NENT],
  input  logic [PBW-1:0]   ent_wid  [NENT],
  output logic [VLW-1:0]   vlen,
  output logic [PBW-1:0]   width
);
  logic           marked;
  logic           hit;
  logic [VLW-1:0] hit_vlen;
  logic [PBW-1:0] hit_wid;

  always_comb begin
    marked   = op_fp ? fp_mask[op_idx] : int_mask[op_idx];
    hit      = 1'b0;
    hit_vlen = VLW'(1);
    hit_wid  = def_width;
    // scan from the top so the lowest-numbered match is the last one kept
    for (int k = NENT - 1; k >= 0; k--) begin
      if (ent_en[k] && (ent_fp[k] == op_fp) && (ent_idx[k] == op_idx)) begin
        hit      = 1'b1;
        hit_vlen = ent_vlen[k];
        hit_wid  = ent_wid[k];
      end
    end
    if (op_en && marked && hit) begin
      vlen  = hit_vlen;
      width = hit_wid;
    end else begin
      vlen  = VLW'(1);
      width = def_width;
    end
  end
endmodule

// File: rtl/vcfg_classify.sv
module vcfg_classify
  import vcfg_pkg::*;
#(
  parameter int unsigned NOPS = 3,
  parameter int unsigned VLW  = 8,
  parameter int unsigned PBW  = 2
) (
  input  logic           op_en [NOPS],
  input  logic [VLW-1:0] vlen  [NOPS],
  input  logic [PBW-1:0] width [NOPS],
  input  logic [PBW-1:0] def_width,
  output logic [1:0]     cls,
  output logic           bypass
);
  logic        any_vec, any_pack;
  insn_class_e cls_e;

  always_comb begin
    any_vec  = 1'b0;
    any_pack = 1'b0;
    for (int i = 0; i < NOPS; i++) begin
      if (op_en[i] && (vlen[i] > VLW'(1))) any_vec  = 1'b1;
      if (op_en[i] && (width[i] != def_width)) any_pack = 1'b1;
    end
    cls_e  = insn_class_e'({any_pack, any_vec});
    cls    = cls_e;
    bypass = (cls_e == CLS_PASS);
  end
endmodule

// File: rtl/vcfg_decoder.sv
module vcfg_decoder
  import vcfg_pkg::*;
#(
  parameter int unsigned NREGS = 32,
  parameter int unsigned NENT  = 2,
  parameter int unsigned VLW   = 8,
  parameter int unsigned PBW   = 2
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               cfg_we,
  input  logic [$clog2(NENT+ADDR_ENT0)-1:0]  cfg_addr,
  input  logic [CFG_DW-1:0]                  cfg_wdata,
  input  logic [PBW-1:0]                     def_width,
  input  logic                               dst_en,
  input  logic                               dst_fp,
  input  logic [$clog2(NREGS)-1:0]           dst_idx,
  input  logic                               src1_en,
  input  logic                               src1_fp,
  input  logic [$clog2(NREGS)-1:0]           src1_idx,
  input  logic                               src2_en,
  input  logic                               src2_fp,
  input  logic [$clog2(NREGS)-1:0]           src2_idx,
  output logic [VLW-1:0]                     dst_vlen,
  output logic [PBW-1:0]                     dst_width,
  output logic [VLW-1:0]                     src1_vlen,
  output logic [PBW-1:0]                     src1_width,
  output logic [VLW-1:0]                     src2_vlen,
  output logic [PBW-1:0]                     src2_width,
  output logic [1:0]                         insn_class,
  output logic                               bypass
);
  localparam int unsigned IDXW  = $clog2(NREGS);
  localparam int unsigned ADDRW = $clog2(NENT + ADDR_ENT0);
  localparam int unsigned NOPS  = 3;

  logic [NREGS-1:0] int_mask, fp_mask;
  logic             ent_en   [NENT];
  logic             ent_fp   [NENT];
  logic [IDXW-1:0]  ent_idx  [NENT];
  logic [VLW-1:0]   ent_vlen [NENT];
  logic [PBW-1:0]   ent_wid  [NENT];

  logic             op_en    [NOPS];
  logic             op_fp    [NOPS];
  logic [IDXW-1:0]  op_idx   [NOPS];
  logic [VLW-1:0]   op_vlen  [NOPS];
  logic [PBW-1:0]   op_wid   [NOPS];

  vcfg_store #(
    .NREGS(NREGS), .NENT(NENT), .IDXW(IDXW),
    .VLW(VLW), .PBW(PBW), .ADDRW(ADDRW)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .int_mask(int_mask), .fp_mask(fp_mask),
    .ent_en(ent_en), .ent_fp(ent_fp), .ent_idx(ent_idx),
    .ent_vlen(ent_vlen), .ent_wid(ent_wid)
  );

  always_comb begin
    op_en[0] = dst_en;  op_fp[0] = dst_fp;  op_idx[0] = dst_idx;
    op_en[1] = src1_en; op_fp[1] = src1_fp; op_idx[1] = src1_idx;
    op_en[2] = src2_en; op_fp[2] = src2_fp; op_idx[2] = src2_idx;
  end

  for (genvar i = 0; i < NOPS; i++) begin : g_op
    vcfg_lookup #(
      .NREGS(NREGS), .NENT(NENT), .IDXW(IDXW), .VLW(VLW), .PBW(PBW)
    ) u_lookup (
      .op_en(op_en[i]), .op_fp(op_fp[i]), .op_idx(op_idx[i]),
      .def_width(def_width), .int_mask(int_mask), .fp_mask(fp_mask),
      .ent_en(ent_en), .ent_fp(ent_fp), .ent_idx(ent_idx),
      .ent_vlen(ent_vlen), .ent_wid(ent_wid),
      .vlen(op_vlen[i]), .width(op_wid[i])
    );
  end

  always_comb begin
    dst_vlen   = op_vlen[0]; dst_width  = op_wid[0];
    src1_vlen  = op_vlen[1]; src1_width = op_wid[1];
    src2_vlen  = op_vlen[2]; src2_width = op_wid[2];
  end

  vcfg_classify #(.NOPS(NOPS), .VLW(VLW), .PBW(PBW)) u_classify (
    .op_en(op_en), .vlen(op_vlen), .width(op_wid), .def_width(def_width),
    .cls(insn_class), .bypass(bypass)
  );
endmodule

// File: rtl/vcfg_decoder_chk.sv
module vcfg_decoder_chk #(
  parameter int unsigned NREGS = 32,
  parameter int unsigned VLW   = 8,
  parameter int unsigned PBW   = 2,
  parameter int unsigned IDXW  = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic [PBW-1:0]   def_width,
  input logic             dst_en,
  input logic             dst_fp,
  input logic [IDXW-1:0]  dst_idx,
  input logic             src1_en,
  input logic             src2_en,
  input logic [VLW-1:0]   dst_vlen,
  input logic [PBW-1:0]   dst_width,
  input logic [VLW-1:0]   src1_vlen,
  input logic [PBW-1:0]   src1_width,
  input logic [VLW-1:0]   src2_vlen,
  input logic [PBW-1:0]   src2_width,
  input logic [1:0]       insn_class,
  input logic             bypass,
  input logic [NREGS-1:0] int_mask,
  input logic [NREGS-1:0] fp_mask
);
  // R8: bypass only when every operand looks scalar at default width
  a_r8_bypass_scalar: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |-> (dst_vlen <= VLW'(1) && src1_vlen <= VLW'(1) && src2_vlen <= VLW'(1)
                && dst_width == def_width && src1_width == def_width
                && src2_width == def_width));

  // R7: an enabled long destination forces the vector bit
  a_r7_vec_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_en && dst_vlen > VLW'(1)) |-> insn_class[0]);

  // R7: an enabled non-default source width forces the packed bit
  a_r7_pack_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (src1_en && src1_width != def_width) |-> insn_class[1]);

  // R10: absent operand reports scalar default
  a_r10_absent_scalar: assert property (@(posedge clk) disable iff (!rst_n)
    !src2_en |-> (src2_vlen == VLW'(1) && src2_width == def_width));

  // R2: unmasked integer destination stays scalar
  a_r2_unmasked_scalar: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_en && !dst_fp && !int_mask[dst_idx]) |-> (dst_vlen == VLW'(1)));

  // R9: masks change only after a write
  a_r9_masks_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> ($stable(int_mask) && $stable(fp_mask)));
endmodule

bind vcfg_decoder vcfg_decoder_chk #(
  .NREGS(NREGS), .VLW(VLW), .PBW(PBW), .IDXW(IDXW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .def_width(def_width),
  .dst_en(dst_en), .dst_fp(dst_fp), .dst_idx(dst_idx),
  .src1_en(src1_en), .src2_en(src2_en),
  .dst_vlen(dst_vlen), .dst_width(dst_width),
  .src1_vlen(src1_vlen), .src1_width(src1_width),
  .src2_vlen(src2_vlen), .src2_width(src2_width),
  .insn_class(insn_class), .bypass(bypass),
  .int_mask(int_mask), .fp_mask(fp_mask)
);

// File: tb/tb_vcfg_decoder.sv
module tb_vcfg_decoder;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic [1:0]  def_width;
  logic        dst_en, dst_fp, src1_en, src1_fp, src2_en, src2_fp;
  logic [4:0]  dst_idx, src1_idx, src2_idx;
  logic [7:0]  dst_vlen, src1_vlen, src2_vlen;
  logic [1:0]  dst_width, src1_width, src2_width, insn_class;
  logic        bypass;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  vcfg_decoder dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .def_width(def_width),
    .dst_en(dst_en), .dst_fp(dst_fp), .dst_idx(dst_idx),
    .src1_en(src1_en), .src1_fp(src1_fp), .src1_idx(src1_idx),
    .src2_en(src2_en), .src2_fp(src2_fp), .src2_idx(src2_idx),
    .dst_vlen(dst_vlen), .dst_width(dst_width),
    .src1_vlen(src1_vlen), .src1_width(src1_width),
    .src2_vlen(src2_vlen), .src2_width(src2_width),
    .insn_class(insn_class), .bypass(bypass)
  );

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ent(input logic en, input logic fp,
                                      input logic [4:0] idx, input logic [7:0] vl,
                                      input logic [1:0] w);
    ent = 32'b0;
    ent[31] = en; ent[7] = fp; ent[4:0] = idx; ent[15:8] = vl; ent[17:16] = w;
  endfunction

  // write lands on the next rising edge; return 1 ns after it
  task automatic cfg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic set_dst(input logic en, input logic fp, input logic [4:0] idx);
    dst_en = en; dst_fp = fp; dst_idx = idx; #1;
  endtask

  task automatic t_reset();
    set_dst(1, 0, 5'd3);
    check("R1", "dst_vlen", dst_vlen, 8'd1);
    check("R1", "dst_width", {6'b0, dst_width}, 8'd2);
    check("R1", "src1_vlen", src1_vlen, 8'd1);
    check("R1", "class", {6'b0, insn_class}, 8'd0);
    check("R1", "bypass", {7'b0, bypass}, 8'd1);
  endtask

  task automatic t_mask_and_match();
    cfg_write(2'd2, ent(1, 0, 5'd3, 8'd4, 2'd1));
    set_dst(1, 0, 5'd3);
    check("R2", "unmasked dst_vlen", dst_vlen, 8'd1);
    check("R2", "unmasked dst_width", {6'b0, dst_width}, 8'd2);
    cfg_write(2'd0, 32'h0000_0008);
    check("R3", "matched dst_vlen", dst_vlen, 8'd4);
    check("R3", "matched dst_width", {6'b0, dst_width}, 8'd1);
    check("R7", "vector-packed class", {6'b0, insn_class}, 8'd3);
    check("R8", "bypass low", {7'b0, bypass}, 8'd0);
  endtask

  task automatic t_file_and_nomatch();
    cfg_write(2'd1, 32'h0000_0008);
    set_dst(1, 1, 5'd3);
    check("R4", "fp reg vs int entry vlen", dst_vlen, 8'd1);
    check("R4", "fp reg vs int entry width", {6'b0, dst_width}, 8'd2);
    cfg_write(2'd0, 32'h0000_0018);
    set_dst(1, 0, 5'd4);
    check("R6", "masked no-match vlen", dst_vlen, 8'd1);
    check("R6", "masked no-match width", {6'b0, dst_width}, 8'd2);
  endtask

  task automatic t_priority();
    cfg_write(2'd3, ent(1, 0, 5'd3, 8'd9, 2'd0));
    set_dst(1, 0, 5'd3);
    check("R5", "lower entry wins vlen", dst_vlen, 8'd4);
    check("R5", "lower entry wins width", {6'b0, dst_width}, 8'd1);
    cfg_write(2'd2, ent(0, 0, 5'd3, 8'd4, 2'd1));
    check("R11", "disabled entry skipped vlen", dst_vlen, 8'd9);
    check("R11", "disabled entry skipped width", {6'b0, dst_width}, 8'd0);
  endtask

  task automatic t_classes();
    cfg_write(2'd3, ent(0, 0, 5'd0, 8'd1, 2'd0));
    cfg_write(2'd2, ent(1, 0, 5'd3, 8'd6, 2'd2));
    set_dst(1, 0, 5'd3);
    check("R7", "vector-only class", {6'b0, insn_class}, 8'd1);
    cfg_write(2'd2, ent(1, 0, 5'd3, 8'd1, 2'd3));
    check("R7", "packed-only class", {6'b0, insn_class}, 8'd2);
    check("R8", "packed bypass low", {7'b0, bypass}, 8'd0);
    cfg_write(2'd2, ent(1, 0, 5'd3, 8'd1, 2'd2));
    check("R7", "pass class", {6'b0, insn_class}, 8'd0);
    check("R8", "pass bypass high", {7'b0, bypass}, 8'd1);
  endtask

  task automatic t_absent();
    cfg_write(2'd2, ent(1, 0, 5'd3, 8'd5, 2'd0));
    set_dst(1, 0, 5'd7);
    src2_en = 1'b0; src2_fp = 1'b0; src2_idx = 5'd3; #1;
    check("R10", "absent src2 vlen", src2_vlen, 8'd1);
    check("R10", "absent src2 width", {6'b0, src2_width}, 8'd2);
    check("R10", "absent src2 class", {6'b0, insn_class}, 8'd0);
    src2_en = 1'b1; #1;
    check("R10", "present src2 vlen", src2_vlen, 8'd5);
    src2_en = 1'b0; #1;
  endtask

  task automatic t_timing();
    set_dst(1, 0, 5'd3);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 2'd2; cfg_wdata = ent(1, 0, 5'd3, 8'd12, 2'd2);
    #1;
    check("R9", "old value during write", dst_vlen, 8'd5);
    @(posedge clk); #1;
    cfg_we = 1'b0;
    check("R9", "new value after edge", dst_vlen, 8'd12);
  endtask

  initial begin
    #100000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    def_width = 2'd2;
    dst_en = 1'b0; dst_fp = 1'b0; dst_idx = '0;
    src1_en = 1'b1; src1_fp = 1'b0; src1_idx = 5'd4;
    src2_en = 1'b0; src2_fp = 1'b0; src2_idx = 5'd5;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    src1_idx = 5'd9;
    t_reset();
    t_mask_and_match();
    t_file_and_nomatch();
    t_priority();
    t_classes();
    t_absent();
    t_timing();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule